// File: doc/BRIEF.md
# Sixteen-bit timer with byte-staged register access

This block is a 16-bit free-running timer. It holds a count register, two compare registers and one capture register. A processor with an 8-bit data bus reaches all four registers through one shared byte latch, called the staging byte. Each 16-bit value therefore moves as one consistent whole, provided software keeps the correct byte order.

On a read, the high byte is returned from the register itself. Reading the high byte of the count or capture register also copies the register's low byte into the staging byte. A later low-byte read returns that frozen copy. On a write, the high byte is parked in the staging byte. The low-byte write then commits both bytes to the target register in a single clock. Compare registers are read directly, both bytes, and the staging byte is not touched. Writes to them still pass through the staging byte.

On the timer side, a tick input advances the count. A capture pulse input snapshots the count into the capture register. Two match outputs pulse when the count reaches either compare value.

Top module: `tmr16_bytebus`

## Requirements
- R1: The block resets synchronously while `rst_n` is low. After reset, the count and capture registers read 0x0000, both compare registers read 0xFFFF, and the staging byte is 0x00.
- R2: The register map uses `bus_addr` values 0 to 7:
  - Even addresses hold high bytes and odd addresses hold low bytes.
  - 0/1 is the count, 2/3 is compare A, 4/5 is compare B, and 6/7 is capture.
  - A read at address 0 or 6 returns the register's high byte and copies its low byte into the staging byte at the same clock edge.
  - A read at address 1 or 7 returns the staging byte.
- R3: Reads at addresses 2 to 5 return the addressed byte of the compare register directly and leave the staging byte unchanged.
- R4: A write at address 0, 2 or 4 changes only the staging byte. A write at address 1, 3 or 5 loads {staging byte, write data} into the matching register at that clock edge.
- R5: Writes at addresses 6 and 7 have no effect: the capture register and the staging byte keep their values.
- R6: A low-byte access with no matching high-byte access before it uses whatever the staging byte currently holds, even if another register left it there.
- R7: Each cycle with `cnt_tick` high adds one to the count, and 0xFFFF wraps to 0x0000.
- R8: When a count low-byte write and a tick fall in the same cycle, the written value is loaded and the increment is lost.
- R9: A `cap_pulse` in cycle k is registered once. The capture register then loads the count value held during cycle k+1.
- R10: `match_a` (`match_b`) is high for the one cycle after an edge where the count was updated, by a tick or a write, to a value equal to compare A (B).
- R11: `bus_rdata` is 0x00 when `bus_rd` is low. A cycle with both strobes high acts as a write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Byte offset within the block |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, valid in the strobe cycle |
| cnt_tick | input | 1 | Count enable for one increment |
| cap_pulse | input | 1 | Capture request |
| match_a | output | 1 | Count reached compare A |
| match_b | output | 1 | Count reached compare B |

## Verification
The bench reads the count high byte in the same cycle as a tick, then reads the low byte a cycle later. A design that failed to freeze the low byte would return the advanced value instead of the snapshot.

It commits a count write together with a tick. A design that let the tick win would be off by one.

It interleaves compare reads and capture writes between high and low accesses, and issues a low-byte write with no high byte before it. A design that routed compare reads or capture writes through the staging byte would corrupt a later low-byte result.

The wrap from 0xFFFF, the two-cycle capture latency and the single-cycle match pulse are each probed at the exact cycle they take effect.

// File: rtl/tmr16_pkg.sv
// Shared definitions for the byte-staged timer: widths, register selector
// and address decode helpers. Assumes a 16-bit count split into two bytes.
package tmr16_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 3;
    localparam int N_CMP  = 2;

    typedef enum logic [1:0] {
        SEL_CNT  = 2'd0,
        SEL_CMPA = 2'd1,
        SEL_CMPB = 2'd2,
        SEL_CAP  = 2'd3
    } reg_sel_t;

    // Register selected by a byte offset (pairs of bytes per register).
    function automatic reg_sel_t addr_sel(input logic [ADDR_W-1:0] a);
        return reg_sel_t'(a[ADDR_W-1:1]);
    endfunction
endpackage

// File: rtl/tmr16_stage.sv
// Bus side of the timer: address decode, the shared staging byte and the
// read-data mux. Assumes one strobe per access; a write strobe takes
// precedence over a read strobe in the same cycle.
module tmr16_stage
    import tmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [CNT_W-1:0]  cmp_a_val,
    input  logic [CNT_W-1:0]  cmp_b_val,
    input  logic [CNT_W-1:0]  cap_val,
    output logic [BYTE_W-1:0] temp_val,
    output logic              ld_cnt,
    output logic [N_CMP-1:0]  ld_cmp,
    output logic [CNT_W-1:0]  ld_word,
    output logic [BYTE_W-1:0] bus_rdata
);
    reg_sel_t sel;
    logic     is_lo;
    logic     rd_only;

    // Decode the offset into a register selector and a byte half.
    always_comb begin
        sel     = addr_sel(bus_addr);
        is_lo   = bus_addr[0];
        rd_only = bus_rd && !bus_wr;
    end

    // Low-byte writes commit {staging, data}; capture has no write path.
    always_comb begin
        ld_word   = {temp_val, bus_wdata};
        ld_cnt    = bus_wr && is_lo && (sel == SEL_CNT);
        ld_cmp[0] = bus_wr && is_lo && (sel == SEL_CMPA);
        ld_cmp[1] = bus_wr && is_lo && (sel == SEL_CMPB);
    end

    // Staging byte: high-byte writes park data, high-byte reads freeze low byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp_val <= '0;
        end else if (bus_wr && !is_lo && (sel != SEL_CAP)) begin
            temp_val <= bus_wdata;
        end else if (rd_only && !is_lo && (sel == SEL_CNT)) begin
            temp_val <= cnt_val[BYTE_W-1:0];
        end else if (rd_only && !is_lo && (sel == SEL_CAP)) begin
            temp_val <= cap_val[BYTE_W-1:0];
        end
    end

    // Read mux: compare bytes direct, count and capture low bytes from staging.
    always_comb begin
        bus_rdata = '0;
        if (rd_only) begin
            unique case (sel)
                SEL_CNT:  bus_rdata = is_lo ? temp_val : cnt_val[CNT_W-1:BYTE_W];
                SEL_CMPA: bus_rdata = is_lo ? cmp_a_val[BYTE_W-1:0] : cmp_a_val[CNT_W-1:BYTE_W];
                SEL_CMPB: bus_rdata = is_lo ? cmp_b_val[BYTE_W-1:0] : cmp_b_val[CNT_W-1:BYTE_W];
                SEL_CAP:  bus_rdata = is_lo ? temp_val : cap_val[CNT_W-1:BYTE_W];
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tmr16_counter.sv
// Free-running count register. A bus load overrides the tick in the same
// cycle. Exposes the next value and an update flag for the match logic.
module tmr16_counter
    import tmr16_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_word,
    output logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] cnt_next,
    output logic             cnt_upd
);
    // Next-value selection: load first, then increment with natural wrap.
    always_comb begin
        cnt_upd  = ld || tick;
        cnt_next = ld ? ld_word : (tick ? cnt_val + CNT_W'(1) : cnt_val);
    end

    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_val <= '0;
        else        cnt_val <= cnt_next;
    end
endmodule

// File: rtl/tmr16_cmp_chan.sv
// One compare channel: a bus-loaded compare register and a registered match
// flag raised when the count is updated to equal the compare value.
module tmr16_cmp_chan
    import tmr16_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_word,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic             cnt_upd,
    output logic [CNT_W-1:0] cmp_val,
    output logic             match
);
    // Compare register load.
    always_ff @(posedge clk) begin
        if (!rst_n)  cmp_val <= '1;
        else if (ld) cmp_val <= ld_word;
    end

    // Single-cycle match flag on an update that lands on the compare value.
    always_ff @(posedge clk) begin
        if (!rst_n) match <= 1'b0;
        else        match <= cnt_upd && (cnt_next == cmp_val);
    end
endmodule

// File: rtl/tmr16_capture.sv
// Capture register: the request is registered once, then the count is
// copied. Read-only from the bus; no write path exists.
module tmr16_capture
    import tmr16_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pulse,
    input  logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] cap_val
);
    logic cap_q;

    // Register the capture request.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= 1'b0;
        else        cap_q <= cap_pulse;
    end

    // Snapshot the count one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n)     cap_val <= '0;
        else if (cap_q) cap_val <= cnt_val;
    end
endmodule

// File: rtl/tmr16_bytebus.sv
// Top of the byte-staged 16-bit timer. Wires the bus stage, the counter,
// the compare channels and the capture unit. Assumes a synchronous bus
// with single-cycle strobes.
module tmr16_bytebus
    import tmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              cnt_tick,
    input  logic              cap_pulse,
    output logic              match_a,
    output logic              match_b
);
    logic [CNT_W-1:0]            cnt_val;
    logic [CNT_W-1:0]            cnt_next;
    logic                        cnt_upd;
    logic [CNT_W-1:0]            cap_val;
    logic [BYTE_W-1:0]           temp_val;
    logic                        ld_cnt;
    logic [N_CMP-1:0]            ld_cmp;
    logic [CNT_W-1:0]            ld_word;
    logic [N_CMP-1:0][CNT_W-1:0] cmp_val;
    logic [N_CMP-1:0]            match_v;
    logic [CNT_W-1:0]            cmp_a_val;
    logic [CNT_W-1:0]            cmp_b_val;

    // Name the two compare channels for the bus mux and the checker.
    always_comb begin
        cmp_a_val = cmp_val[0];
        cmp_b_val = cmp_val[1];
        match_a   = match_v[0];
        match_b   = match_v[1];
    end

    tmr16_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .cnt_val   (cnt_val),
        .cmp_a_val (cmp_a_val),
        .cmp_b_val (cmp_b_val),
        .cap_val   (cap_val),
        .temp_val  (temp_val),
        .ld_cnt    (ld_cnt),
        .ld_cmp    (ld_cmp),
        .ld_word   (ld_word),
        .bus_rdata (bus_rdata)
    );

    tmr16_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (cnt_tick),
        .ld       (ld_cnt),
        .ld_word  (ld_word),
        .cnt_val  (cnt_val),
        .cnt_next (cnt_next),
        .cnt_upd  (cnt_upd)
    );

    for (genvar gi = 0; gi < N_CMP; gi++) begin : g_cmp
        tmr16_cmp_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld       (ld_cmp[gi]),
            .ld_word  (ld_word),
            .cnt_next (cnt_next),
            .cnt_upd  (cnt_upd),
            .cmp_val  (cmp_val[gi]),
            .match    (match_v[gi])
        );
    end

    tmr16_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_pulse (cap_pulse),
        .cnt_val   (cnt_val),
        .cap_val   (cap_val)
    );
endmodule

// File: rtl/tmr16_bytebus_chk.sv
// Assertion checker for the byte-staged timer, bound to the top module.
// Watches the bus, the register state and the staging byte over time.
module tmr16_bytebus_chk
    import tmr16_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic              cnt_tick,
    input logic              cap_pulse,
    input logic              match_a,
    input logic              match_b,
    input logic [CNT_W-1:0]  cnt_val,
    input logic [CNT_W-1:0]  cmp_a_val,
    input logic [CNT_W-1:0]  cmp_b_val,
    input logic [CNT_W-1:0]  cap_val,
    input logic [BYTE_W-1:0] temp_val
);
    assert_lo_read_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == 3'd1) |-> bus_rdata == temp_val);

    assert_cmp_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == 3'd5) |-> bus_rdata == cmp_b_val[BYTE_W-1:0]);

    assert_cmp_keeps_stage_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr[2:1] inside {2'd1, 2'd2}) |=> $stable(temp_val));

    assert_hi_write_stage_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0) |=> temp_val == $past(bus_wdata));

    assert_cmp_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd3) |=> cmp_a_val == {$past(temp_val), $past(bus_wdata)});

    assert_cap_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[2:1] == 2'd3) |=> $stable(temp_val));

    assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && !(bus_wr && bus_addr == 3'd1)) |=> cnt_val == $past(cnt_val) + 16'd1);

    assert_load_beats_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd1) |=> cnt_val == {$past(temp_val), $past(bus_wdata)});

    assert_capture_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> ##1 (cap_val == $past(cnt_val)));

    assert_match_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
        match_a |-> cnt_val == cmp_a_val);

    assert_match_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
        match_b |-> cnt_val == cmp_b_val);

    assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == '0);
endmodule

bind tmr16_bytebus tmr16_bytebus_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_tick  (cnt_tick),
    .cap_pulse (cap_pulse),
    .match_a   (match_a),
    .match_b   (match_b),
    .cnt_val   (cnt_val),
    .cmp_a_val (cmp_a_val),
    .cmp_b_val (cmp_b_val),
    .cap_val   (cap_val),
    .temp_val  (temp_val)
);

// File: tb/tmr16_bytebus_tb.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases followed by seeded random
// traffic, all compared against a behavioural model kept in the bench.
module tmr16_bytebus_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cnt_tick = 1'b0;
    logic       cap_pulse = 1'b0;
    logic       match_a;
    logic       match_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    string cur_req = "R1";
    logic [7:0] last_rd;

    // Behavioural model state.
    logic [15:0] m_cnt, m_a, m_b, m_cap;
    logic [7:0]  m_temp;
    logic        m_capq, m_ma, m_mb;

    always #10 clk = ~clk;

    tmr16_bytebus u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_tick(cnt_tick), .cap_pulse(cap_pulse),
        .match_a(match_a), .match_b(match_b)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_cnt[15:8];
            3'd2: return m_a[15:8];
            3'd3: return m_a[7:0];
            3'd4: return m_b[15:8];
            3'd5: return m_b[7:0];
            3'd6: return m_cap[15:8];
            default: return m_temp;
        endcase
    endfunction

    task automatic model_reset();
        m_cnt = 16'h0000; m_a = 16'hFFFF; m_b = 16'hFFFF; m_cap = 16'h0000;
        m_temp = 8'h00; m_capq = 1'b0; m_ma = 1'b0; m_mb = 1'b0;
    endtask

    // One bus/timer cycle: drive after a falling edge, check read data,
    // advance the model at the rising edge, then check the match outputs.
    task automatic cyc(input logic rd, input logic wr, input logic [2:0] a,
                       input logic [7:0] d, input logic tk, input logic cp);
        logic [15:0] nxt;
        logic        ldc, upd;
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
        cnt_tick = tk; cap_pulse = cp;
        #5;
        last_rd = bus_rdata;
        if (rd && !wr) check(cur_req, {8'h00, bus_rdata}, {8'h00, exp_rd(a)});
        else check("R11", {8'h00, bus_rdata}, 16'h0000);
        @(posedge clk);
        ldc = wr && a == 3'd1;
        nxt = ldc ? {m_temp, d} : (tk ? m_cnt + 16'd1 : m_cnt);
        upd = ldc || tk;
        m_ma = upd && nxt == m_a;
        m_mb = upd && nxt == m_b;
        if (wr && a == 3'd3) m_a = {m_temp, d};
        if (wr && a == 3'd5) m_b = {m_temp, d};
        if (wr && !a[0] && a != 3'd6) m_temp = d;
        else if (!wr && rd && a == 3'd0) m_temp = m_cnt[7:0];
        else if (!wr && rd && a == 3'd6) m_temp = m_cap[7:0];
        if (m_capq) m_cap = m_cnt;
        m_capq = cp;
        m_cnt = nxt;
        #1;
        check("R10", {15'd0, match_a}, {15'd0, m_ma});
        check("R10", {15'd0, match_b}, {15'd0, m_mb});
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; cnt_tick = 1'b0; cap_pulse = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        cur_req = req;
        cyc(1'b1, 1'b0, a, 8'h00, 1'b0, 1'b0);
        check(req, {8'h00, last_rd}, {8'h00, exp});
    endtask

    task automatic wr_b(input logic [2:0] a, input logic [7:0] d);
        cyc(1'b0, 1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic idle(input logic tk);
        cyc(1'b0, 1'b0, 3'd0, 8'h00, tk, 1'b0);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values through the bus.
        rd_chk("R1", 3'd0, 8'h00); rd_chk("R1", 3'd1, 8'h00);
        rd_chk("R1", 3'd2, 8'hFF); rd_chk("R1", 3'd3, 8'hFF);
        rd_chk("R1", 3'd4, 8'hFF); rd_chk("R1", 3'd5, 8'hFF);
        rd_chk("R1", 3'd6, 8'h00); rd_chk("R1", 3'd7, 8'h00);

        // R4: a high write alone does not reach the register; the low write commits.
        wr_b(3'd2, 8'h12);
        rd_chk("R4", 3'd2, 8'hFF); rd_chk("R4", 3'd3, 8'hFF);
        wr_b(3'd3, 8'h34);
        rd_chk("R4", 3'd2, 8'h12); rd_chk("R4", 3'd3, 8'h34);

        // R7: increment and wrap from 0xFFFE.
        wr_b(3'd0, 8'hFF); wr_b(3'd1, 8'hFE);
        idle(1'b1);
        rd_chk("R7", 3'd0, 8'hFF); rd_chk("R7", 3'd1, 8'hFF);
        idle(1'b1);
        rd_chk("R7", 3'd0, 8'h00); rd_chk("R7", 3'd1, 8'h00);

        // R8: a load in the same cycle as a tick wins.
        wr_b(3'd0, 8'h12);
        cyc(1'b0, 1'b1, 3'd1, 8'h34, 1'b1, 1'b0);
        rd_chk("R8", 3'd0, 8'h12); rd_chk("R8", 3'd1, 8'h34);

        // R2: the high read freezes the low byte while counting goes on.
        wr_b(3'd0, 8'h12); wr_b(3'd1, 8'hFF);
        cur_req = "R2";
        cyc(1'b1, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0);
        check("R2", {8'h00, last_rd}, 16'h0012);
        idle(1'b1);
        rd_chk("R2", 3'd1, 8'hFF);
        rd_chk("R2", 3'd0, 8'h13);

        // R3: compare reads are direct and leave the staging byte alone.
        wr_b(3'd4, 8'hAB); wr_b(3'd5, 8'hCD);
        rd_chk("R3", 3'd5, 8'hCD); rd_chk("R3", 3'd4, 8'hAB);
        rd_chk("R3", 3'd1, 8'hAB);

        // R6: a low write with no high write uses the stale staging byte.
        wr_b(3'd3, 8'h11);
        rd_chk("R6", 3'd2, 8'hAB); rd_chk("R6", 3'd3, 8'h11);

        // R5: capture writes change neither capture nor staging byte.
        wr_b(3'd6, 8'h77); wr_b(3'd7, 8'h88);
        rd_chk("R5", 3'd1, 8'hAB);
        rd_chk("R5", 3'd6, 8'h00); rd_chk("R5", 3'd7, 8'h00);

        // R9: capture takes the count held in the cycle after the pulse.
        wr_b(3'd0, 8'h01); wr_b(3'd1, 8'h00);
        cyc(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b1);
        idle(1'b1);
        rd_chk("R9", 3'd6, 8'h01); rd_chk("R9", 3'd7, 8'h01);

        // R10: match A pulses once when the count reaches 0x0005.
        wr_b(3'd2, 8'h00); wr_b(3'd3, 8'h05);
        wr_b(3'd0, 8'h00); wr_b(3'd1, 8'h03);
        idle(1'b1);
        check("R10", {15'd0, match_a}, 16'd0);
        idle(1'b1);
        check("R10", {15'd0, match_a}, 16'd1);
        idle(1'b0);
        check("R10", {15'd0, match_a}, 16'd0);
        // R10: match B on a direct count load equal to compare B.
        wr_b(3'd4, 8'h00); wr_b(3'd5, 8'h09);
        wr_b(3'd0, 8'h00); wr_b(3'd1, 8'h09);
        check("R10", {15'd0, match_b}, 16'd1);

        // R11: both strobes act as a write only.
        cur_req = "R11";
        cyc(1'b1, 1'b1, 3'd4, 8'h5A, 1'b0, 1'b0);
        rd_chk("R11", 3'd7, 8'h5A);

        // Seeded random traffic against the model.
        void'($urandom(32'd4242));
        cur_req = "R6";
        for (int i = 0; i < 3000; i++) begin
            int op = $urandom % 4;
            logic [2:0] a = 3'($urandom % 8);
            logic [7:0] d = 8'($urandom);
            logic tk = ($urandom % 3) != 0;
            logic cp = ($urandom % 16) == 0;
            cyc(op == 1, op == 2, a, d, tk, cp);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule